// File: doc/BRIEF.md
# Compressed-Cache Index Predictor

A compressed, direct-mapped DRAM cache can place a line under either of two index functions. The first is traditional set indexing, where consecutive lines fall into consecutive sets. The second is bandwidth-aware indexing, which folds each even/odd pair of neighbouring lines into one set, so that a single 72-byte access (8 bytes of tag room plus 64 bytes of data) can return both halves when they compress well. This block makes the choice at install time from the line's compressed size. On reads it guesses which of the two functions holds the line, using a 1-bit-per-entry history table indexed by a fold of the page number.

On a read, the block issues a first probe under the predicted index. It issues a second probe under the other index only when the first one misses and the two functions name different sets for that line. When the read resolves, the history entry records where the line was found. An install writes the entry with the index that was chosen for it. The block also counts predictions and mispredictions. The compression engine, the DRAM timing and the data path are outside the block.

Top module: `cip_predictor`

## Requirements
- R1: An install accepted on a clock edge raises `inst_done` for exactly the next cycle. `inst_scheme` is then 1 (bandwidth-aware) when `inst_size` is at most 32 bytes, and 0 (traditional) otherwise. `inst_ready` is always 1.
- R2: With line address L = addr[31:6], the traditional set is L[13:0] and the bandwidth-aware set is {L[13:1], L[14]}. `inst_set` and `probe_set` carry the set of the scheme they report.
- R3: The cycle after a read is accepted, `probe_valid` is 1 for one cycle with `probe_second` = 0. `probe_scheme` equals the stored history bit of the read's page. After reset every bit is 0, so the scheme is traditional.
- R4: The history entry of an address is addr[21:12] XOR addr[31:22], giving 1024 entries.
- R5: A hit reported for the first probe ends the read. In the next cycle `rd_done` = 1, `rd_hit` = 1, `rd_scheme` = the predicted scheme and `rd_mispred` = 0, and no second probe follows.
- R6: A first-probe miss where the two sets differ gives one more `probe_valid` cycle, the cycle after the result, with `probe_second` = 1 and the opposite scheme. Its result yields `rd_done` the cycle after, with `rd_hit` = `rd_mispred` = the result's hit.
- R7: A first-probe miss where both schemes name the same set ends the read with `rd_done` = 1 and `rd_hit` = 0, with no second probe.
- R8: A read that hits writes the scheme it was found under into its page's entry. A read that misses everywhere leaves the entry unchanged. An install writes its chosen scheme.
- R9: When an install and a resolving read write the same entry on the same edge, the install's value is kept.
- R10: `pred_count` rises by one on every accepted read. `mispred_count` rises by one on every read whose second probe hits.
- R11: `rd_ready` is 0 from acceptance until `rd_done`. `res_valid` has no effect while no probe result is awaited.
- R12: After reset no pulse output is high, both counters are 0 and `rd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Install request |
| inst_ready | output | 1 | Install accepted (always 1) |
| inst_addr | input | 32 | Install line address |
| inst_size | input | 7 | Compressed size in bytes, 0 to 64 |
| inst_done | output | 1 | Install decision pulse |
| inst_scheme | output | 1 | Chosen scheme, 0 traditional, 1 bandwidth-aware |
| inst_set | output | 14 | Set under the chosen scheme |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read accepted when high |
| rd_addr | input | 32 | Read line address |
| probe_valid | output | 1 | Probe request pulse |
| probe_second | output | 1 | Probe is the retry at the other index |
| probe_scheme | output | 1 | Scheme of the probe |
| probe_set | output | 14 | Set to probe |
| res_valid | input | 1 | Probe result strobe |
| res_hit | input | 1 | Probe found the line |
| rd_done | output | 1 | Read resolved pulse |
| rd_hit | output | 1 | Line was found |
| rd_scheme | output | 1 | Scheme the line was found under |
| rd_mispred | output | 1 | Line found only by the second probe |
| pred_count | output | 16 | Accepted reads |
| mispred_count | output | 16 | Reads found on the second probe |

## Verification
Reads are tried in four shapes: a first-probe hit, a miss followed by a hit at the other index, a miss under both indices, and a miss where both indices name the same set. These tell apart the hit, mispredict, absent and aliased endings. Installs are run at sizes 0, 32, 33 and 40 to pin the half-line threshold. A later read of the same page then shows that the history entry took the chosen scheme. Two pages whose number folds to the same entry show that the hash is shared. An install landing on the same edge as a read's update shows which writer wins.

// File: rtl/cip_pkg.sv
package cip_pkg;
    typedef enum logic {
        SCH_TSI = 1'b0,
        SCH_BAI = 1'b1
    } scheme_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P1,
        ST_W1,
        ST_P2,
        ST_W2
    } rd_state_e;
endpackage

// File: rtl/cip_page_hash.sv
module cip_page_hash #(
    parameter int PN_W  = 20,
    parameter int IDX_W = 10
) (
    input  logic [PN_W-1:0]  page,
    output logic [IDX_W-1:0] idx
);
    localparam int CHUNKS = (PN_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [PAD_W-1:0] page_pad;

    always_comb begin
        page_pad = '0;
        page_pad[PN_W-1:0] = page;
        idx = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            idx = idx ^ page_pad[c*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/cip_index_map.sv
module cip_index_map #(
    parameter int SET_W = 14
) (
    input  logic [SET_W:0]   line_lo,
    input  logic             bai_sel,
    output logic [SET_W-1:0] set,
    output logic             same_set
);
    logic [SET_W-1:0] tsi_set;
    logic [SET_W-1:0] bai_set;

    assign tsi_set = line_lo[SET_W-1:0];

    generate
        if (SET_W > 1) begin : g_wide
            assign bai_set = {line_lo[SET_W-1:1], line_lo[SET_W]};
        end else begin : g_narrow
            assign bai_set = line_lo[SET_W];
        end
    endgenerate

    assign same_set = (tsi_set == bai_set);
    assign set      = bai_sel ? bai_set : tsi_set;
endmodule

// File: rtl/cip_ltt.sv
module cip_ltt #(
    parameter int ENTRIES = 1024,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  logic             ins_we,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic             ins_bit,
    input  logic             upd_we,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_bit
);
    logic [ENTRIES-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (upd_we) bits_d[upd_idx] = upd_bit;
        // install written last so it wins on a shared entry
        if (ins_we) bits_d[ins_idx] = ins_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign rd_bit = bits_q[rd_idx];
endmodule

// File: rtl/cip_predictor.sv
module cip_predictor #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int SET_W      = 14,
    parameter int ENTRIES    = 1024,
    parameter int CNT_W      = 16,
    parameter int SIZE_W     = $clog2(LINE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inst_valid,
    output logic              inst_ready,
    input  logic [ADDR_W-1:0] inst_addr,
    input  logic [SIZE_W-1:0] inst_size,
    output logic              inst_done,
    output logic              inst_scheme,
    output logic [SET_W-1:0]  inst_set,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              probe_valid,
    output logic              probe_second,
    output logic              probe_scheme,
    output logic [SET_W-1:0]  probe_set,
    input  logic              res_valid,
    input  logic              res_hit,
    output logic              rd_done,
    output logic              rd_hit,
    output logic              rd_scheme,
    output logic              rd_mispred,
    output logic [CNT_W-1:0]  pred_count,
    output logic [CNT_W-1:0]  mispred_count
);
    import cip_pkg::*;

    localparam int LINE_OFF = $clog2(LINE_BYTES);
    localparam int PAGE_OFF = $clog2(PAGE_BYTES);
    localparam int IDX_W    = $clog2(ENTRIES);
    localparam int LA_W     = ADDR_W - LINE_OFF;
    localparam int PN_W     = ADDR_W - PAGE_OFF;
    localparam logic [SIZE_W-1:0] HALF = SIZE_W'(LINE_BYTES / 2);

    typedef struct packed {
        rd_state_e        st;
        logic [LA_W-1:0]  line;
        logic [IDX_W-1:0] hidx;
        scheme_e          pred;
        logic             rd_done;
        logic             rd_hit;
        scheme_e          rd_scheme;
        logic             rd_mispred;
        logic             inst_done;
        scheme_e          inst_scheme;
        logic [SET_W-1:0] inst_set;
        logic [CNT_W-1:0] pred_cnt;
        logic [CNT_W-1:0] mis_cnt;
    } state_t;

    state_t r_d, r_q;

    logic [IDX_W-1:0] rd_hash, inst_hash;
    logic             ltt_bit;
    logic             upd_we;
    scheme_e          upd_bit;
    scheme_e          inst_choice;
    scheme_e          cur_scheme;
    logic [SET_W-1:0] inst_map_set;
    logic             inst_alias_unused;
    logic             rd_alias;
    logic             in_second;
    logic             unused_low;

    assign unused_low = ^{rd_addr[LINE_OFF-1:0], inst_addr[LINE_OFF-1:0], inst_alias_unused};

    cip_page_hash #(.PN_W(PN_W), .IDX_W(IDX_W)) u_rd_hash (
        .page (rd_addr[ADDR_W-1:PAGE_OFF]),
        .idx  (rd_hash)
    );

    cip_page_hash #(.PN_W(PN_W), .IDX_W(IDX_W)) u_inst_hash (
        .page (inst_addr[ADDR_W-1:PAGE_OFF]),
        .idx  (inst_hash)
    );

    assign inst_choice = (inst_size <= HALF) ? SCH_BAI : SCH_TSI;

    cip_index_map #(.SET_W(SET_W)) u_inst_map (
        .line_lo  (inst_addr[LINE_OFF +: SET_W+1]),
        .bai_sel  (inst_choice == SCH_BAI),
        .set      (inst_map_set),
        .same_set (inst_alias_unused)
    );

    assign in_second  = (r_q.st == ST_P2) || (r_q.st == ST_W2);
    assign cur_scheme = in_second ? scheme_e'(~r_q.pred) : r_q.pred;

    cip_index_map #(.SET_W(SET_W)) u_rd_map (
        .line_lo  (r_q.line[SET_W:0]),
        .bai_sel  (cur_scheme == SCH_BAI),
        .set      (probe_set),
        .same_set (rd_alias)
    );

    cip_ltt #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ltt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_hash),
        .rd_bit  (ltt_bit),
        .ins_we  (inst_valid),
        .ins_idx (inst_hash),
        .ins_bit (inst_choice == SCH_BAI),
        .upd_we  (upd_we),
        .upd_idx (r_q.hidx),
        .upd_bit (upd_bit == SCH_BAI)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rd_done   = 1'b0;
        r_d.inst_done = 1'b0;
        upd_we        = 1'b0;
        upd_bit       = cur_scheme;

        if (inst_valid) begin
            r_d.inst_done   = 1'b1;
            r_d.inst_scheme = inst_choice;
            r_d.inst_set    = inst_map_set;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (rd_valid) begin
                    r_d.st       = ST_P1;
                    r_d.line     = rd_addr[ADDR_W-1:LINE_OFF];
                    r_d.hidx     = rd_hash;
                    r_d.pred     = scheme_e'(ltt_bit);
                    r_d.pred_cnt = r_q.pred_cnt + 1'b1;
                end
            end
            ST_P1: r_d.st = ST_W1;
            ST_P2: r_d.st = ST_W2;
            ST_W1, ST_W2: begin
                if (res_valid) begin
                    if (res_hit || rd_alias || r_q.st == ST_W2) begin
                        r_d.st         = ST_IDLE;
                        r_d.rd_done    = 1'b1;
                        r_d.rd_hit     = res_hit;
                        r_d.rd_scheme  = cur_scheme;
                        r_d.rd_mispred = res_hit && (r_q.st == ST_W2);
                        upd_we         = res_hit;
                        if (res_hit && r_q.st == ST_W2) begin
                            r_d.mis_cnt = r_q.mis_cnt + 1'b1;
                        end
                    end else begin
                        r_d.st = ST_P2;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pred: SCH_TSI, rd_scheme: SCH_TSI,
                     inst_scheme: SCH_TSI, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign inst_ready    = 1'b1;
    assign inst_done     = r_q.inst_done;
    assign inst_scheme   = (r_q.inst_scheme == SCH_BAI);
    assign inst_set      = r_q.inst_set;
    assign rd_ready      = (r_q.st == ST_IDLE);
    assign probe_valid   = (r_q.st == ST_P1) || (r_q.st == ST_P2);
    assign probe_second  = (r_q.st == ST_P2);
    assign probe_scheme  = (cur_scheme == SCH_BAI);
    assign rd_done       = r_q.rd_done;
    assign rd_hit        = r_q.rd_hit;
    assign rd_scheme     = (r_q.rd_scheme == SCH_BAI);
    assign rd_mispred    = r_q.rd_mispred;
    assign pred_count    = r_q.pred_cnt;
    assign mispred_count = r_q.mis_cnt;
endmodule

// File: rtl/cip_predictor_chk.sv
module cip_predictor_chk #(
    parameter int SIZE_W     = 7,
    parameter int CNT_W      = 16,
    parameter int LINE_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inst_valid,
    input logic [SIZE_W-1:0] inst_size,
    input logic              inst_done,
    input logic              inst_scheme,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              probe_valid,
    input logic              probe_second,
    input logic              probe_scheme,
    input logic              rd_done,
    input logic              rd_hit,
    input logic              rd_mispred,
    input logic [CNT_W-1:0]  pred_count,
    input logic [CNT_W-1:0]  mispred_count
);
    localparam logic [SIZE_W-1:0] HALF = SIZE_W'(LINE_BYTES / 2);

    logic first_scheme_q;
    logic seen_second_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_scheme_q <= 1'b0;
            seen_second_q  <= 1'b0;
        end else begin
            if (probe_valid && !probe_second) first_scheme_q <= probe_scheme;
            if (rd_done)                          seen_second_q  <= 1'b0;
            else if (probe_valid && probe_second) seen_second_q  <= 1'b1;
        end
    end

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> !rd_ready);

    // R3
    probe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |=> !probe_valid);

    // R6
    second_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && probe_second) |-> (probe_scheme != first_scheme_q));

    // R5
    mispred_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_mispred) |-> (rd_hit && seen_second_q));

    // R10
    mis_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mispred_count != $past(mispred_count)) |-> (rd_done && rd_mispred));

    // R10
    pred_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_valid && rd_ready) |-> (pred_count == $past(pred_count) + 1'b1));

    // R1
    inst_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inst_valid) |-> (inst_done && (inst_scheme == ($past(inst_size) <= HALF))));

    // R12
    inst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(inst_valid) |-> !inst_done);
endmodule

bind cip_predictor cip_predictor_chk #(
    .SIZE_W(SIZE_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/tb_cip_predictor.sv
`timescale 1ns/100ps
module tb_cip_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inst_valid = 1'b0;
    logic        inst_ready;
    logic [31:0] inst_addr = '0;
    logic [6:0]  inst_size = '0;
    logic        inst_done, inst_scheme;
    logic [13:0] inst_set;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [31:0] rd_addr = '0;
    logic        probe_valid, probe_second, probe_scheme;
    logic [13:0] probe_set;
    logic        res_valid = 1'b0, res_hit = 1'b0;
    logic        rd_done, rd_hit, rd_scheme, rd_mispred;
    logic [15:0] pred_count, mispred_count;

    int n_chk = 0, n_fail = 0;
    int m_pred = 0, m_mis = 0;
    bit ltt_m [1024];
    bit cmp_on = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cip_predictor dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R4: entry = addr[21:12] ^ addr[31:22]
    function automatic int hash_f(input logic [31:0] a);
        return int'(a[21:12] ^ a[31:22]);
    endfunction

    // R2: traditional = L[13:0], bandwidth-aware = {L[13:1], L[14]}
    function automatic int set_f(input logic [31:0] a, input bit bai);
        logic [13:0] t;
        t = a[19:6];
        if (bai) t = {a[19:7], a[20]};
        return int'(t);
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(pred_count == 16'(m_pred), "R10", "pred_count", pred_count, m_pred);
            chk(mispred_count == 16'(m_mis), "R10", "mispred_count", mispred_count, m_mis);
        end
    end

    task automatic do_inst(input logic [31:0] a, input int sz);
        bit exp_s;
        exp_s = (sz <= 32);
        @(negedge clk);
        inst_valid = 1'b1; inst_addr = a; inst_size = 7'(sz);
        @(posedge clk);
        @(negedge clk);
        inst_valid = 1'b0;
        chk(inst_done == 1'b1, "R1", "inst_done", inst_done, 1);
        chk(inst_scheme == exp_s, "R1", "inst_scheme", inst_scheme, exp_s);
        chk(inst_set == 14'(set_f(a, exp_s)), "R2", "inst_set", inst_set, set_f(a, exp_s));
        ltt_m[hash_f(a)] = exp_s;
    endtask

    task automatic do_read(input logic [31:0] a, input bit h1, input bit h2,
                           input bit coll, input logic [31:0] ca, input int csz);
        bit pred, alias_s;
        int h;
        h = hash_f(a);
        pred = ltt_m[h];
        alias_s = (set_f(a, 1'b0) == set_f(a, 1'b1));
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        @(posedge clk);
        m_pred++;
        @(negedge clk);
        rd_valid = 1'b0;
        chk(probe_valid == 1'b1, "R3", "probe_valid", probe_valid, 1);
        chk(probe_second == 1'b0, "R3", "probe_second", probe_second, 0);
        chk(probe_scheme == pred, "R3", "probe_scheme", probe_scheme, pred);
        chk(probe_set == 14'(set_f(a, pred)), "R2", "probe_set", probe_set, set_f(a, pred));
        chk(rd_ready == 1'b0, "R11", "rd_ready busy", rd_ready, 0);
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b1; res_hit = h1;
        if (coll) begin
            inst_valid = 1'b1; inst_addr = ca; inst_size = 7'(csz);
        end
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b0; inst_valid = 1'b0;
        if (h1) begin
            chk(rd_done && rd_hit, "R5", "done/hit", {rd_done, rd_hit}, 3);
            chk(rd_scheme == pred, "R5", "rd_scheme", rd_scheme, pred);
            chk(rd_mispred == 1'b0, "R5", "rd_mispred", rd_mispred, 0);
            chk(probe_valid == 1'b0, "R5", "no second probe", probe_valid, 0);
            ltt_m[h] = pred;
        end else if (alias_s) begin
            chk(rd_done && !rd_hit, "R7", "done/miss", {rd_done, rd_hit}, 2);
            chk(probe_valid == 1'b0, "R7", "no second probe", probe_valid, 0);
        end else begin
            chk(rd_done == 1'b0, "R6", "not done yet", rd_done, 0);
            chk(probe_valid && probe_second, "R6", "second probe", {probe_valid, probe_second}, 3);
            chk(probe_scheme == !pred, "R6", "second scheme", probe_scheme, !pred);
            chk(probe_set == 14'(set_f(a, !pred)), "R2", "second set", probe_set, set_f(a, !pred));
            @(posedge clk);
            @(negedge clk);
            res_valid = 1'b1; res_hit = h2;
            @(posedge clk);
            if (h2) m_mis++;
            @(negedge clk);
            res_valid = 1'b0;
            chk(rd_done && (rd_hit == h2), "R6", "done/hit2", {rd_done, rd_hit}, {1'b1, h2});
            chk(rd_mispred == h2, "R6", "rd_mispred", rd_mispred, h2);
            if (h2) begin
                chk(rd_scheme == !pred, "R6", "rd_scheme", rd_scheme, !pred);
                ltt_m[h] = !pred;
            end
        end
        if (coll) ltt_m[hash_f(ca)] = (csz <= 32);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!probe_valid && !rd_done && !inst_done, "R12", "pulses idle",
            {probe_valid, rd_done, inst_done}, 0);
        chk(rd_ready && inst_ready, "R12", "ready", {rd_ready, inst_ready}, 3);

        // R6 R8 mispredict, found at bandwidth-aware index
        do_read(32'h1220_5040, 1'b0, 1'b1, 1'b0, '0, 0);
        // R5 R8 now predicted bandwidth-aware, first hit
        do_read(32'h1220_5040, 1'b1, 1'b0, 1'b0, '0, 0);

        // R1 threshold boundaries
        do_inst(32'h0800_3000, 40);
        do_inst(32'h0800_3000, 33);
        do_inst(32'h0900_1000, 0);
        do_inst(32'h0800_3000, 32);
        // R8 install wrote bandwidth-aware
        do_read(32'h0800_3040, 1'b1, 1'b0, 1'b0, '0, 0);

        // R7 aliased miss, entry left as set by install
        do_inst(32'h1220_6000, 16);
        do_read(32'h1220_6000, 1'b0, 1'b0, 1'b0, '0, 0);
        do_read(32'h1220_6000, 1'b1, 1'b0, 1'b0, '0, 0);

        // R8 miss under both indices, entry unchanged
        do_read(32'h3320_7040, 1'b0, 1'b0, 1'b0, '0, 0);
        do_read(32'h3320_7040, 1'b1, 1'b0, 1'b0, '0, 0);

        // R4 two pages folding to entry 5
        do_inst(32'h0000_5000, 8);
        do_read(32'h0040_4000, 1'b1, 1'b0, 1'b0, '0, 0);

        // R9 same-edge install beats read update
        do_read(32'h5550_9040, 1'b1, 1'b0, 1'b1, 32'h5550_9080, 10);
        do_read(32'h5550_9040, 1'b1, 1'b0, 1'b0, '0, 0);

        // R11 result strobe while idle is ignored
        @(negedge clk);
        res_valid = 1'b1; res_hit = 1'b1;
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b0;
        chk(rd_done == 1'b0, "R11", "idle result", rd_done, 0);
        chk(rd_ready == 1'b1, "R11", "still ready", rd_ready, 1);
        repeat (2) @(negedge clk);

        finished = 1'b1;
        cmp_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule